// File: doc/BRIEF.md
# Four-Lane Byte-Sliced Data FIFO

This block buffers data between a register-level host and a byte-serial engine. It stores data in four independent byte lanes, each a 16-entry first-in first-out store. A write or read through the 32-bit word port moves one byte in every lane in the same cycle. Byte k of the word belongs to lane k, so a word access sees 64 bytes of room. A write or read through the byte port touches only the lane chosen by a rotating lane pointer, so a byte access sees the 16 bytes of that lane. There is one pointer for writes and one for reads. Each pointer steps 0, 1, 2, 3 and wraps after every accepted byte access. Word accesses do not move the pointers.

One instance serves the transmit direction: the host writes words or bytes and the serial engine pulls bytes. A second instance serves the receive direction: the engine pushes bytes and the host reads words or bytes. Because of the lane rotation, the byte stream order matches the byte order inside the words. The status outputs show whether a word or a byte can be written (full), whether the buffer is half occupied, and whether a whole word or a single byte is ready to read. The block ignores an access it cannot honour and reports it with a one-cycle illegal-access pulse.

Top module: `quad_lane_fifo`

## Requirements
- R1: After reset every lane is empty, both lane pointers are at lane 0, and full_word, full_byte, half_word, half_byte, avail_word, avail_byte and illegal are all 0.
- R2: A word write puts bits [8k+7:8k] into lane k. A word read takes one byte from every lane. Words come back in the order they were written, on rd_word_data, in the cycle after the read strobe.
- R3: A byte write goes to the lane selected by the write pointer, and a byte read takes from the lane selected by the read pointer. Each pointer advances 0,1,2,3 and then wraps, only on an accepted byte access. A word written as 0x44332211 therefore reads back through the byte port as 0x11, 0x22, 0x33, 0x44, and rd_byte_data is valid in the cycle after the strobe.
- R4: The word port accepts 16 words (64 bytes). full_word is 1 whenever any lane holds 16 bytes.
- R5: full_byte is 1 when the lane under the write pointer holds 16 bytes. After 61 byte writes from empty, full_word is 1 while full_byte is 0. After 64 byte writes, full_byte is 1.
- R6: half_word is 1 when the four lanes together hold at least 32 bytes. half_byte is 1 when the lane under the write pointer holds at least 8 bytes.
- R7: avail_word is 1 when every lane holds at least one byte. avail_byte is 1 when the lane under the read pointer holds at least one byte.
- R8: A write while the matching full flag is 1, or a read while the matching avail flag is 0, changes no storage and no pointer. Such an access raises illegal for exactly one cycle, in the cycle after the strobe.
- R9: Asserting the word and byte strobes of the same side (write or read) in one cycle is ignored on that side and raises illegal.
- R10: A legal write and a legal read in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_word_en | input | 1 | Write one word across all lanes |
| wr_word_data | input | 32 | Word to write, byte k to lane k |
| wr_byte_en | input | 1 | Write one byte to the lane under the write pointer |
| wr_byte_data | input | 8 | Byte to write |
| rd_word_en | input | 1 | Read one word across all lanes |
| rd_word_data | output | 32 | Word from the last word read (registered) |
| rd_byte_en | input | 1 | Read one byte from the lane under the read pointer |
| rd_byte_data | output | 8 | Byte from the last byte read |
| full_word | output | 1 | Some lane is full; a word write would be refused |
| full_byte | output | 1 | Lane under the write pointer is full |
| half_word | output | 1 | At least half of the total capacity is occupied |
| half_byte | output | 1 | Lane under the write pointer is at least half occupied |
| avail_word | output | 1 | Every lane holds a byte; a word can be read |
| avail_byte | output | 1 | Lane under the read pointer holds a byte |
| illegal | output | 1 | One-cycle pulse for a refused access |

## Verification
The bench builds the block with its default parameters: four lanes of sixteen entries. With these values a complete 64-byte fill and drain takes well under a hundred cycles. That makes every full, half and empty threshold reachable in a directed run, along with several complete wraps of both lane pointers. The 61-byte fill case leaves one lane full while the write pointer rests on a lane that still has room. This separates the word-granular and byte-granular full flags. Mixed word-in/byte-out traffic checks that the lane order matches the byte order inside a word.

// File: rtl/qlf_pkg.sv
package qlf_pkg;

  // Access kind on one side, from the pair {byte strobe, word strobe}
  typedef enum logic [1:0] {
    ACC_IDLE = 2'd0,
    ACC_WORD = 2'd1,
    ACC_BYTE = 2'd2,
    ACC_BOTH = 2'd3
  } acc_e;

  function automatic acc_e acc_decode(input logic word_en, input logic byte_en);
    return acc_e'({byte_en, word_en});
  endfunction

endpackage

// File: rtl/qlf_lane.sv
// One byte lane: circular store with a synchronous read register.
module qlf_lane #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic [DW-1:0]                din,
  input  logic                         pop,
  output logic [DW-1:0]                dout,
  output logic [$clog2(DEPTH+1)-1:0]   cnt
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
      dout <= '0;
    end else begin
      if (push) wptr <= bump(wptr);
      if (pop) begin
        rptr <= bump(rptr);
        dout <= mem[rptr];
      end
      case ({push, pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

endmodule

// File: rtl/qlf_rotor.sv
// Rotating lane pointer, steps 0..N-1 and wraps.
module qlf_rotor #(
  parameter int N = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 step,
  output logic [$clog2(N)-1:0] ptr
);
  localparam int PW = $clog2(N);

  always_ff @(posedge clk) begin
    if (rst)       ptr <= '0;
    else if (step) ptr <= (ptr == PW'(N-1)) ? '0 : ptr + 1'b1;
  end

endmodule

// File: rtl/quad_lane_fifo.sv
module quad_lane_fifo #(
  parameter int LANES = 4,
  parameter int DEPTH = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_word_en,
  input  logic [LANES*8-1:0]   wr_word_data,
  input  logic                 wr_byte_en,
  input  logic [7:0]           wr_byte_data,
  input  logic                 rd_word_en,
  output logic [LANES*8-1:0]   rd_word_data,
  input  logic                 rd_byte_en,
  output logic [7:0]           rd_byte_data,
  output logic                 full_word,
  output logic                 full_byte,
  output logic                 half_word,
  output logic                 half_byte,
  output logic                 avail_word,
  output logic                 avail_byte,
  output logic                 illegal
);
  import qlf_pkg::*;

  localparam int LW = 8;
  localparam int CW = $clog2(DEPTH+1);
  localparam int TW = $clog2(LANES*DEPTH+1);
  localparam int PW = $clog2(LANES);

  acc_e wop, rop;
  logic [CW-1:0]    cnt [LANES];
  logic [LW-1:0]    lq  [LANES];
  logic [LW-1:0]    din [LANES];
  logic [LANES-1:0] lane_push, lane_pop, lane_full, lane_empty;
  logic [PW-1:0]    wlane, rlane, sel_q;
  logic [TW-1:0]    total;
  logic             word_wr_ok, byte_wr_ok, word_rd_ok, byte_rd_ok;
  logic             bad_wr, bad_rd;

  assign wop = acc_decode(wr_word_en, wr_byte_en);
  assign rop = acc_decode(rd_word_en, rd_byte_en);

  // flags, all from registered lane state
  assign full_word  = |lane_full;
  assign full_byte  = lane_full[wlane];
  assign avail_word = ~|lane_empty;
  assign avail_byte = ~lane_empty[rlane];
  assign half_word  = total >= TW'(LANES*DEPTH/2);
  assign half_byte  = cnt[wlane] >= CW'(DEPTH/2);

  always_comb begin
    total = '0;
    for (int i = 0; i < LANES; i++) total = total + TW'(cnt[i]);
  end

  assign word_wr_ok = (wop == ACC_WORD) && !full_word;
  assign byte_wr_ok = (wop == ACC_BYTE) && !full_byte;
  assign word_rd_ok = (rop == ACC_WORD) && avail_word;
  assign byte_rd_ok = (rop == ACC_BYTE) && avail_byte;

  assign bad_wr = (wop == ACC_BOTH) || ((wop == ACC_WORD) && full_word) ||
                  ((wop == ACC_BYTE) && full_byte);
  assign bad_rd = (rop == ACC_BOTH) || ((rop == ACC_WORD) && !avail_word) ||
                  ((rop == ACC_BYTE) && !avail_byte);

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign lane_push[i]  = word_wr_ok || (byte_wr_ok && (wlane == PW'(i)));
      assign lane_pop[i]   = word_rd_ok || (byte_rd_ok && (rlane == PW'(i)));
      assign din[i]        = (wop == ACC_WORD) ? wr_word_data[i*LW +: LW] : wr_byte_data;
      assign lane_full[i]  = cnt[i] == CW'(DEPTH);
      assign lane_empty[i] = cnt[i] == '0;
      assign rd_word_data[i*LW +: LW] = lq[i];

      qlf_lane #(.DEPTH(DEPTH), .DW(LW)) u_lane (
        .clk  (clk),
        .rst  (rst),
        .push (lane_push[i]),
        .din  (din[i]),
        .pop  (lane_pop[i]),
        .dout (lq[i]),
        .cnt  (cnt[i])
      );
    end
  endgenerate

  qlf_rotor #(.N(LANES)) u_wrot (
    .clk (clk), .rst (rst), .step (byte_wr_ok), .ptr (wlane)
  );

  qlf_rotor #(.N(LANES)) u_rrot (
    .clk (clk), .rst (rst), .step (byte_rd_ok), .ptr (rlane)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= '0;
      illegal <= 1'b0;
    end else begin
      if (byte_rd_ok) sel_q <= rlane;
      illegal <= bad_wr || bad_rd;
    end
  end

  assign rd_byte_data = lq[sel_q];

endmodule

// File: rtl/qlf_chk.sv
module qlf_chk (
  input logic clk,
  input logic rst,
  input logic wr_word_en,
  input logic wr_byte_en,
  input logic rd_word_en,
  input logic rd_byte_en,
  input logic full_word,
  input logic full_byte,
  input logic half_byte,
  input logic avail_word,
  input logic avail_byte,
  input logic illegal
);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!full_word && !full_byte && !avail_word && !avail_byte && !illegal));

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    (full_word && wr_word_en && !wr_byte_en) |=> illegal);

  p_full_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (full_word && !rd_word_en && !rd_byte_en) |=> full_word);

  p_full_half_r6: assert property (@(posedge clk) disable iff (rst)
    full_byte |-> half_byte);

  p_avail_order_r7: assert property (@(posedge clk) disable iff (rst)
    avail_word |-> avail_byte);

  p_no_underflow_r8: assert property (@(posedge clk) disable iff (rst)
    (!avail_byte && rd_byte_en && !rd_word_en) |=> illegal);

  p_dual_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_word_en && wr_byte_en) |=> illegal);

endmodule

bind quad_lane_fifo qlf_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_word_en (wr_word_en),
  .wr_byte_en (wr_byte_en),
  .rd_word_en (rd_word_en),
  .rd_byte_en (rd_byte_en),
  .full_word  (full_word),
  .full_byte  (full_byte),
  .half_byte  (half_byte),
  .avail_word (avail_word),
  .avail_byte (avail_byte),
  .illegal    (illegal)
);

// File: tb/quad_lane_fifo_test.sv
module quad_lane_fifo_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_word_en, wr_byte_en, rd_word_en, rd_byte_en;
  logic [31:0] wr_word_data, rd_word_data;
  logic [7:0]  wr_byte_data, rd_byte_data;
  logic        full_word, full_byte, half_word, half_byte;
  logic        avail_word, avail_byte, illegal;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_lane_fifo uut (
    .clk (clk), .rst (rst),
    .wr_word_en (wr_word_en), .wr_word_data (wr_word_data),
    .wr_byte_en (wr_byte_en), .wr_byte_data (wr_byte_data),
    .rd_word_en (rd_word_en), .rd_word_data (rd_word_data),
    .rd_byte_en (rd_byte_en), .rd_byte_data (rd_byte_data),
    .full_word (full_word), .full_byte (full_byte),
    .half_word (half_word), .half_byte (half_byte),
    .avail_word (avail_word), .avail_byte (avail_byte),
    .illegal (illegal)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock with the given strobes; returns at the next falling edge
  task automatic cyc(input logic ww, input logic wb, input logic rw, input logic rb,
                     input logic [31:0] wd, input logic [7:0] bd);
    wr_word_en = ww; wr_byte_en = wb; rd_word_en = rw; rd_byte_en = rb;
    wr_word_data = wd; wr_byte_data = bd;
    @(negedge clk);
    wr_word_en = 1'b0; wr_byte_en = 1'b0; rd_word_en = 1'b0; rd_byte_en = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 flags", {25'd0, full_word, full_byte, half_word, half_byte,
                       avail_word, avail_byte, illegal}, 32'd0);
  endtask

  task automatic t_word_roundtrip();
    cyc(1, 0, 0, 0, 32'hDEADBEEF, 8'h0);
    cyc(1, 0, 0, 0, 32'h01234567, 8'h0);
    cyc(1, 0, 0, 0, 32'hCAFEF00D, 8'h0);
    cyc(0, 0, 1, 0, 32'h0, 8'h0);
    check("R2 word 0", rd_word_data, 32'hDEADBEEF);
    cyc(0, 0, 1, 0, 32'h0, 8'h0);
    check("R2 word 1", rd_word_data, 32'h01234567);
    cyc(0, 0, 1, 0, 32'h0, 8'h0);
    check("R2 word 2", rd_word_data, 32'hCAFEF00D);
    check("R2 drained", {31'd0, avail_byte}, 32'd0);
  endtask

  task automatic t_word_to_bytes();
    logic [7:0] expb [4] = '{8'h11, 8'h22, 8'h33, 8'h44};
    cyc(1, 0, 0, 0, 32'h44332211, 8'h0);
    for (int k = 0; k < 4; k++) begin
      cyc(0, 0, 0, 1, 32'h0, 8'h0);
      check("R3 byte order", {24'd0, rd_byte_data}, {24'd0, expb[k]});
    end
    for (int k = 0; k < 8; k++) cyc(0, 1, 0, 0, 32'h0, 8'(8'h50 + k));
    cyc(0, 0, 1, 0, 32'h0, 8'h0);
    check("R3 bytes to word 0", rd_word_data, 32'h53525150);
    cyc(0, 0, 1, 0, 32'h0, 8'h0);
    check("R3 bytes to word 1", rd_word_data, 32'h57565554);
  endtask

  task automatic t_word_capacity();
    logic okall = 1'b1;
    do_reset();
    for (int k = 0; k < 16; k++) begin
      cyc(1, 0, 0, 0, 32'hA0B0C000 + k, 8'h0);
      if (k == 6) check("R6 half_word below", {31'd0, half_word}, 32'd0);
      if (k == 7) check("R6 half_word at 32", {31'd0, half_word}, 32'd1);
      if (k < 15 && full_word) okall = 1'b0;
    end
    check("R4 not full early", {31'd0, okall}, 32'd1);
    check("R4 full_word", {31'd0, full_word}, 32'd1);
    check("R5 full_byte on word fill", {31'd0, full_byte}, 32'd1);
    cyc(1, 0, 0, 0, 32'hFFFFFFFF, 8'h0);
    check("R8 overflow illegal", {31'd0, illegal}, 32'd1);
    cyc(0, 0, 0, 0, 32'h0, 8'h0);
    check("R8 illegal one cycle", {31'd0, illegal}, 32'd0);
    okall = 1'b1;
    for (int k = 0; k < 16; k++) begin
      cyc(0, 0, 1, 0, 32'h0, 8'h0);
      if (rd_word_data !== 32'hA0B0C000 + k) okall = 1'b0;
    end
    check("R4 all 16 words intact", {31'd0, okall}, 32'd1);
    cyc(0, 0, 1, 0, 32'h0, 8'h0);
    check("R8 underflow illegal", {31'd0, illegal}, 32'd1);
    check("R8 underflow keeps data", rd_word_data, 32'hA0B0C00F);
  endtask

  task automatic t_byte_fill();
    do_reset();
    for (int k = 0; k < 64; k++) begin
      cyc(0, 1, 0, 0, 32'h0, 8'(k));
      if (k == 27) begin
        check("R6 half_byte below", {31'd0, half_byte}, 32'd0);
        check("R6 half_word below", {31'd0, half_word}, 32'd0);
      end
      if (k == 31) begin
        check("R6 half_byte at 8", {31'd0, half_byte}, 32'd1);
        check("R6 half_word at 32", {31'd0, half_word}, 32'd1);
      end
      if (k == 60) begin
        check("R5 word full after 61", {31'd0, full_word}, 32'd1);
        check("R5 byte not full after 61", {31'd0, full_byte}, 32'd0);
      end
    end
    check("R5 byte full after 64", {31'd0, full_byte}, 32'd1);
    cyc(0, 1, 0, 0, 32'h0, 8'hEE);
    check("R8 byte overflow illegal", {31'd0, illegal}, 32'd1);
    for (int k = 0; k < 4; k++) begin
      cyc(0, 0, 0, 1, 32'h0, 8'h0);
      check("R3 byte stream out", {24'd0, rd_byte_data}, k);
    end
  endtask

  task automatic t_avail();
    do_reset();
    for (int k = 0; k < 3; k++) cyc(0, 1, 0, 0, 32'h0, 8'(8'h70 + k));
    check("R7 avail_byte", {31'd0, avail_byte}, 32'd1);
    check("R7 no avail_word", {31'd0, avail_word}, 32'd0);
    cyc(0, 0, 1, 0, 32'h0, 8'h0);
    check("R8 word underflow illegal", {31'd0, illegal}, 32'd1);
    cyc(0, 1, 0, 0, 32'h0, 8'h73);
    check("R7 avail_word", {31'd0, avail_word}, 32'd1);
    cyc(0, 0, 1, 0, 32'h0, 8'h0);
    check("R8 refused read left data", rd_word_data, 32'h73727170);
  endtask

  task automatic t_dual();
    do_reset();
    cyc(1, 1, 0, 0, 32'h12345678, 8'h9A);
    check("R9 dual write illegal", {31'd0, illegal}, 32'd1);
    check("R9 dual write stored nothing", {31'd0, avail_byte}, 32'd0);
    cyc(1, 0, 0, 0, 32'h0BADF00D, 8'h0);
    cyc(0, 0, 1, 1, 32'h0, 8'h0);
    check("R9 dual read illegal", {31'd0, illegal}, 32'd1);
    cyc(0, 0, 1, 0, 32'h0, 8'h0);
    check("R9 dual read took nothing", rd_word_data, 32'h0BADF00D);
  endtask

  task automatic t_simul();
    do_reset();
    cyc(1, 0, 0, 0, 32'h11110001, 8'h0);
    cyc(1, 0, 0, 0, 32'h11110002, 8'h0);
    cyc(1, 0, 1, 0, 32'h11110003, 8'h0);
    check("R10 read during write", rd_word_data, 32'h11110001);
    check("R10 no illegal", {31'd0, illegal}, 32'd0);
    cyc(0, 0, 1, 0, 32'h0, 8'h0);
    check("R10 second word", rd_word_data, 32'h11110002);
    cyc(0, 0, 1, 0, 32'h0, 8'h0);
    check("R10 written word kept", rd_word_data, 32'h11110003);
    check("R10 empty after", {31'd0, avail_word}, 32'd0);
  endtask

  initial begin
    rst = 1'b1;
    wr_word_en = 0; wr_byte_en = 0; rd_word_en = 0; rd_byte_en = 0;
    wr_word_data = '0; wr_byte_data = '0;
    @(negedge clk);
    t_reset();
    t_word_roundtrip();
    t_word_to_bytes();
    t_word_capacity();
    t_byte_fill();
    t_avail();
    t_dual();
    t_simul();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule